// File: doc/BRIEF.md
# Reference DAC Soft-Slew Sequencer

This block drives the code of a reference DAC and never lets that code jump. Three small configuration registers are loaded through single-cycle write strobes: a signed fine-adjust offset, a pair of margin levels (high and low), and an operation mode. A fourth register picks the slew rate. These registers decide a target code. Whenever a write changes that target, the block waits a fixed start delay. It then walks the DAC code toward the target by one LSB per step interval and stops when the code equals the target.

Timing comes from a tick. The tick is made by dividing the system clock by `TICK_DIV`, which gives 1 µs with the default setting. The start delay is `START_TICKS` ticks. The step interval is `IVL_BASE` ticks shifted left by the 2-bit slew code. Fine-adjust slews and margin slews use the same interval. A target change that arrives during the delay or during a slew restarts the delay. Stepping then resumes from wherever the code stands.

Top module: `refslew_seq`

## Requirements
- R1: After reset, dac_code and dac_target both equal BASE_CODE and busy is 0. The reset register values are: adjust 0, mode normal, margin high DEF_MHIGH, margin low DEF_MLOW, slew code 00.
- R2: A write is taken on a clock edge where wr_en is 1. wr_sel selects the register: 0 is adjust (wr_data[ADJ_W-1:0], two's complement), 1 is margin (high level in wr_data[3:0], low level in wr_data[7:4]), 2 is mode (wr_data[1:0]: 00 normal, 01 margin high, 10 margin low, 11 acts as normal), and 3 is slew code (wr_data[1:0]). dac_target shows the resulting target from the cycle after the write.
- R3: The target is BASE_CODE+adjust in normal mode, BASE_CODE+high level in margin-high mode, and BASE_CODE-low level in margin-low mode. It is clamped to the range 0 to 2**CODE_W-1.
- R4: After a write at edge E that changes the target, dac_code holds its value up to and including edge E+START_TICKS*TICK_DIV-1. It takes its first step at edge E+START_TICKS*TICK_DIV.
- R5: After the first step, further steps come every (IVL_BASE<<code) ticks. With the defaults, slew code 00 gives 4 ticks, 01 gives 8, 10 gives 16 and 11 gives 32.
- R6: Each step moves dac_code by exactly one LSB toward dac_target. Stepping ends when the two are equal, and the code never passes the target.
- R7: Writing margin levels while in normal mode leaves dac_target, dac_code and busy unchanged. The stored level is used once margining is enabled.
- R8: If margin-high mode is enabled before any margin level has been written, the target is BASE_CODE+DEF_MHIGH.
- R9: A target change during the start delay or during a slew restarts the full start delay. Stepping then continues from the current code, in the direction of the new target.
- R10: busy is 1 from the cycle after a target-changing write until the start delay has elapsed and dac_code equals dac_target. Otherwise busy is 0. A write that leaves the target unchanged does not raise busy.
- R11: A write to the slew code never changes dac_target and never starts a delay.
- R12: A margin slew uses the same slew code for its step interval as a fine-adjust slew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | WR_W | Write data |
| dac_code | output | CODE_W | Code currently driven to the DAC |
| dac_target | output | CODE_W | Clamped target code |
| busy | output | 1 | A delay or a slew is in progress |

## Verification
The bench counts the cycles of the start delay exactly, checking the last cycle before the first step and the cycle that contains it. A delay that is off by one tick, or a prescaler that is not realigned on each command, fails here. It reverses a slew mid-way with a margin write, so a design that keeps its old direction, or that does not restart the delay, steps the wrong way or steps too early. It also covers a margin write while margining is disabled, a default level used when margining is enabled first, and mode 11. Finally, it drives an adjust sum past full scale, which would wrap to a low code if the clamp were missing.

// File: rtl/refslew_pkg.sv
package refslew_pkg;

   localparam int MARGIN_W = 4;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'b00,
      MODE_MHIGH  = 2'b01,
      MODE_MLOW   = 2'b10,
      MODE_ALT    = 2'b11
   } op_mode_e;

   typedef enum logic [1:0] {
      SEL_ADJ    = 2'd0,
      SEL_MARGIN = 2'd1,
      SEL_MODE   = 2'd2,
      SEL_SLEW   = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_STEP  = 2'd2
   } seq_state_e;

endpackage

// File: rtl/refslew_tick.sv
module refslew_tick #(
   parameter int TICK_DIV = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic tick
);

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("refslew_tick: TICK_DIV must be at least 1");
      end

      if (TICK_DIV == 1) begin : g_pass
         // every enabled cycle is a tick; a restart still suppresses one
         assign tick = !clear;
      end else begin : g_div
         localparam int CW = $clog2(TICK_DIV);
         localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt <= '0;
            else if (clear)         cnt <= '0;
            else if (cnt == LAST)   cnt <= '0;
            else                    cnt <= cnt + 1'b1;
         end

         assign tick = (cnt == LAST) && !clear;
      end
   endgenerate

endmodule

// File: rtl/refslew_target.sv
module refslew_target
   import refslew_pkg::*;
#(
   parameter int CODE_W    = 8,
   parameter int ADJ_W     = 5,
   parameter int BASE_CODE = 128
) (
   input  logic [ADJ_W-1:0]    adj,
   input  logic [MARGIN_W-1:0] m_hi,
   input  logic [MARGIN_W-1:0] m_lo,
   input  op_mode_e            mode,
   output logic [CODE_W-1:0]   tgt
);

   localparam int MW0 = (CODE_W > ADJ_W) ? CODE_W : ADJ_W;
   localparam int MW1 = (MW0 > MARGIN_W + 1) ? MW0 : MARGIN_W + 1;
   localparam int SW  = MW1 + 2;
   localparam logic signed [SW-1:0] BASE_S = SW'(BASE_CODE);
   localparam logic signed [SW-1:0] MAXC_S = SW'((1 << CODE_W) - 1);

   generate
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_w
         $error("refslew_target: CODE_W out of range");
      end
      if (BASE_CODE < 0 || BASE_CODE > (1 << CODE_W) - 1) begin : g_bad_base
         $error("refslew_target: BASE_CODE outside code range");
      end
      if (ADJ_W < 2) begin : g_bad_adj
         $error("refslew_target: ADJ_W must be at least 2");
      end
   endgenerate

   logic signed [SW-1:0] adj_s, hi_s, off_s, sum_s;

   assign adj_s = signed'({{(SW-ADJ_W){adj[ADJ_W-1]}}, adj});
   assign hi_s  = signed'({{(SW-MARGIN_W){1'b0}}, m_hi});

   always_comb begin
      unique case (mode)
         MODE_MHIGH: off_s = hi_s;
         MODE_MLOW:  off_s = -signed'({{(SW-MARGIN_W){1'b0}}, m_lo});
         default:    off_s = adj_s;
      endcase
      sum_s = BASE_S + off_s;
      if (sum_s[SW-1])          tgt = '0;
      else if (sum_s > MAXC_S)  tgt = MAXC_S[CODE_W-1:0];
      else                      tgt = sum_s[CODE_W-1:0];
   end

endmodule

// File: rtl/refslew_step.sv
module refslew_step
   import refslew_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter int BASE_CODE   = 128,
   parameter int START_TICKS = 50,
   parameter int IVL_BASE    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              restart,
   input  logic [CODE_W-1:0] target,
   input  logic [1:0]        slew_sel,
   output logic [CODE_W-1:0] code,
   output logic              busy
);

   localparam int IVL_MAX = IVL_BASE * 8;
   localparam int IW      = $clog2(IVL_MAX + 1);
   localparam int DW      = $clog2(START_TICKS + 1);
   localparam logic [DW-1:0] DLY_LAST = DW'(START_TICKS - 1);

   generate
      if (START_TICKS < 1) begin : g_bad_dly
         $error("refslew_step: START_TICKS must be at least 1");
      end
      if (IVL_BASE < 1) begin : g_bad_ivl
         $error("refslew_step: IVL_BASE must be at least 1");
      end
   endgenerate

   seq_state_e        state;
   logic [DW-1:0]     dly_cnt;
   logic [IW-1:0]     ivl_cnt;
   logic [IW-1:0]     ivl_len;
   logic [CODE_W-1:0] stepped;
   logic              ivl_done;

   assign ivl_len  = IW'(IVL_BASE) << slew_sel;
   assign ivl_done = (ivl_cnt >= ivl_len - IW'(1));

   always_comb begin
      if (code < target)      stepped = code + 1'b1;
      else if (code > target) stepped = code - 1'b1;
      else                    stepped = code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         dly_cnt <= '0;
         ivl_cnt <= '0;
         code    <= CODE_W'(BASE_CODE);
      end else if (restart) begin
         state   <= ST_DELAY;
         dly_cnt <= '0;
         ivl_cnt <= '0;
      end else begin
         unique case (state)
            ST_DELAY: if (tick) begin
               if (dly_cnt == DLY_LAST) begin
                  code    <= stepped;
                  ivl_cnt <= '0;
                  state   <= (stepped == target) ? ST_IDLE : ST_STEP;
               end else begin
                  dly_cnt <= dly_cnt + 1'b1;
               end
            end
            ST_STEP: if (tick) begin
               if (ivl_done) begin
                  code    <= stepped;
                  ivl_cnt <= '0;
                  if (stepped == target) state <= ST_IDLE;
               end else begin
                  ivl_cnt <= ivl_cnt + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);

endmodule

// File: rtl/refslew_seq.sv
module refslew_seq
   import refslew_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter int ADJ_W       = 5,
   parameter int WR_W        = 8,
   parameter int BASE_CODE   = 128,
   parameter int DEF_MHIGH   = 5,
   parameter int DEF_MLOW    = 5,
   parameter int TICK_DIV    = 125,
   parameter int START_TICKS = 50,
   parameter int IVL_BASE    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [WR_W-1:0]   wr_data,
   output logic [CODE_W-1:0] dac_code,
   output logic [CODE_W-1:0] dac_target,
   output logic              busy
);

   generate
      if (WR_W < 2 * MARGIN_W || WR_W < ADJ_W) begin : g_bad_wr
         $error("refslew_seq: WR_W too narrow for the register fields");
      end
      if (DEF_MHIGH < 0 || DEF_MHIGH >= (1 << MARGIN_W) ||
          DEF_MLOW  < 0 || DEF_MLOW  >= (1 << MARGIN_W)) begin : g_bad_def
         $error("refslew_seq: default margin level does not fit");
      end
   endgenerate

   logic [ADJ_W-1:0]    adj_q,  adj_n;
   logic [MARGIN_W-1:0] mhi_q,  mhi_n, mlo_q, mlo_n;
   op_mode_e            mode_q, mode_n;
   logic [1:0]          sel_q,  sel_n;
   logic [CODE_W-1:0]   tgt_q,  tgt_n;
   logic                restart, tick;

   always_comb begin
      adj_n  = adj_q;
      mhi_n  = mhi_q;
      mlo_n  = mlo_q;
      mode_n = mode_q;
      sel_n  = sel_q;
      if (wr_en) begin
         unique case (reg_sel_e'(wr_sel))
            SEL_ADJ:    adj_n = wr_data[ADJ_W-1:0];
            SEL_MARGIN: begin
               mhi_n = wr_data[MARGIN_W-1:0];
               mlo_n = wr_data[2*MARGIN_W-1:MARGIN_W];
            end
            SEL_MODE:   mode_n = op_mode_e'(wr_data[1:0]);
            default:    sel_n  = wr_data[1:0];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adj_q  <= '0;
         mhi_q  <= MARGIN_W'(DEF_MHIGH);
         mlo_q  <= MARGIN_W'(DEF_MLOW);
         mode_q <= MODE_NORMAL;
         sel_q  <= 2'b00;
         tgt_q  <= CODE_W'(BASE_CODE);
      end else begin
         adj_q  <= adj_n;
         mhi_q  <= mhi_n;
         mlo_q  <= mlo_n;
         mode_q <= mode_n;
         sel_q  <= sel_n;
         tgt_q  <= tgt_n;
      end
   end

   refslew_target #(
      .CODE_W    (CODE_W),
      .ADJ_W     (ADJ_W),
      .BASE_CODE (BASE_CODE)
   ) target_i (
      .adj  (adj_n),
      .m_hi (mhi_n),
      .m_lo (mlo_n),
      .mode (mode_n),
      .tgt  (tgt_n)
   );

   assign restart = (tgt_n != tgt_q);

   refslew_tick #(
      .TICK_DIV (TICK_DIV)
   ) tick_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (restart),
      .tick  (tick)
   );

   refslew_step #(
      .CODE_W      (CODE_W),
      .BASE_CODE   (BASE_CODE),
      .START_TICKS (START_TICKS),
      .IVL_BASE    (IVL_BASE)
   ) step_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .restart  (restart),
      .target   (tgt_q),
      .slew_sel (sel_q),
      .code     (dac_code),
      .busy     (busy)
   );

   assign dac_target = tgt_q;

endmodule

// File: rtl/refslew_seq_chk.sv
module refslew_seq_chk #(
   parameter int CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [CODE_W-1:0] dac_code,
   input logic [CODE_W-1:0] dac_target,
   input logic              busy
);

   localparam logic [CODE_W:0] ONE = (CODE_W+1)'(1);
   logic [CODE_W:0] code_x;
   assign code_x = {1'b0, dac_code};

   AST_ONE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (code_x == $past(code_x) || code_x == $past(code_x) + ONE ||
                code_x + ONE == $past(code_x)));                            // R6

   AST_TOWARD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((!(dac_code > $past(dac_code)) || ($past(dac_target) > $past(dac_code))) &&
                (!(dac_code < $past(dac_code)) || ($past(dac_target) < $past(dac_code))))); // R6

   AST_IDLE_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dac_code == dac_target));                                  // R10

   AST_HOLD_ON_NEW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((dac_target == $past(dac_target)) ||
                (dac_code == $past(dac_code) && busy)));                    // R4

   AST_STILL_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(dac_code));                                         // R10

   AST_SLEW_KEEPS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3) |=> $stable(dac_target));                   // R11

endmodule

bind refslew_seq refslew_seq_chk #(.CODE_W(CODE_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_sel     (wr_sel),
   .dac_code   (dac_code),
   .dac_target (dac_target),
   .busy       (busy)
);

// File: tb/refslew_seq_tb_top.sv
module refslew_seq_tb_top;

   localparam int CW   = 8;
   localparam int BASE = 248;
   localparam int D    = 4;
   localparam int S    = 50;
   localparam int SD   = S * D;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = 2'd0;
   logic [7:0]    wr_data = 8'd0;
   logic [CW-1:0] dac_code, dac_target;
   logic          busy;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   refslew_seq #(
      .CODE_W      (CW),
      .ADJ_W       (5),
      .WR_W        (8),
      .BASE_CODE   (BASE),
      .DEF_MHIGH   (5),
      .DEF_MLOW    (5),
      .TICK_DIV    (D),
      .START_TICKS (S),
      .IVL_BASE    (4)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .dac_code   (dac_code),
      .dac_target (dac_target),
      .busy       (busy)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      wait_cyc(1);
   endtask

   task automatic do_write(input logic [1:0] sel, input logic [7:0] data);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = data;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 reset code", int'(dac_code), BASE);
      chk("R1 reset target", int'(dac_target), BASE);
      chk("R1 reset busy", int'(busy), 0);
   endtask

   task automatic t_adjust_up();
      do_reset();
      do_write(2'd0, 8'd3);
      chk("R2 R3 adjust target", int'(dac_target), BASE + 3);
      chk("R10 busy after write", int'(busy), 1);
      wait_cyc(SD - 1);
      chk("R4 hold to end of delay", int'(dac_code), BASE);
      wait_cyc(1);
      chk("R4 first step", int'(dac_code), BASE + 1);
      wait_cyc(4 * D - 1);
      chk("R5 code 00 interval hold", int'(dac_code), BASE + 1);
      wait_cyc(1);
      chk("R5 R6 second step", int'(dac_code), BASE + 2);
      wait_cyc(4 * D);
      chk("R6 reach target", int'(dac_code), BASE + 3);
      chk("R10 busy low at target", int'(busy), 0);
      wait_cyc(20 * D);
      chk("R6 no overshoot", int'(dac_code), BASE + 3);
   endtask

   task automatic t_slow_down();
      do_reset();
      do_write(2'd3, 8'd3);
      chk("R11 slew write keeps target", int'(dac_target), BASE);
      chk("R11 slew write no busy", int'(busy), 0);
      do_write(2'd0, 8'h1E);
      chk("R3 negative adjust target", int'(dac_target), BASE - 2);
      wait_cyc(SD);
      chk("R4 R6 first step down", int'(dac_code), BASE - 1);
      wait_cyc(32 * D - 1);
      chk("R5 code 11 interval hold", int'(dac_code), BASE - 1);
      wait_cyc(1);
      chk("R5 code 11 step", int'(dac_code), BASE - 2);
      chk("R10 idle after slew", int'(busy), 0);
   endtask

   task automatic t_margin_first();
      do_reset();
      do_write(2'd1, 8'h26);
      chk("R7 margin write target unchanged", int'(dac_target), BASE);
      chk("R7 margin write no busy", int'(busy), 0);
      wait_cyc(10);
      chk("R7 margin write code unchanged", int'(dac_code), BASE);
      do_write(2'd3, 8'd1);
      do_write(2'd2, 8'd1);
      chk("R7 R3 margin high target", int'(dac_target), BASE + 6);
      wait_cyc(SD);
      chk("R12 margin first step", int'(dac_code), BASE + 1);
      wait_cyc(8 * D - 1);
      chk("R12 code 01 hold", int'(dac_code), BASE + 1);
      wait_cyc(1);
      chk("R12 code 01 step", int'(dac_code), BASE + 2);
   endtask

   task automatic t_enable_then_level();
      do_reset();
      do_write(2'd2, 8'd1);
      chk("R8 default margin high", int'(dac_target), BASE + 5);
      wait_cyc(SD);
      chk("R8 first step", int'(dac_code), BASE + 1);
      wait_cyc(4 * D);
      chk("R8 second step", int'(dac_code), BASE + 2);
      do_write(2'd1, 8'h51);
      chk("R9 new level target", int'(dac_target), BASE + 1);
      chk("R9 busy after retarget", int'(busy), 1);
      wait_cyc(SD - 1);
      chk("R9 delay restarted", int'(dac_code), BASE + 2);
      wait_cyc(1);
      chk("R9 reversed step", int'(dac_code), BASE + 1);
      chk("R10 idle after reverse", int'(busy), 0);
   endtask

   task automatic t_retarget_in_delay();
      do_reset();
      do_write(2'd0, 8'd2);
      wait_cyc(100);
      do_write(2'd0, 8'd4);
      chk("R9 retarget value", int'(dac_target), BASE + 4);
      wait_cyc(SD - 1);
      chk("R9 delay restarted in delay", int'(dac_code), BASE);
      wait_cyc(1);
      chk("R9 step after restart", int'(dac_code), BASE + 1);
   endtask

   task automatic t_margin_low_and_alt();
      do_reset();
      do_write(2'd1, 8'h30);
      chk("R7 level write in normal mode", int'(busy), 0);
      do_write(2'd2, 8'd2);
      chk("R3 margin low target", int'(dac_target), BASE - 3);
      do_write(2'd2, 8'd3);
      chk("R2 mode 11 acts as normal", int'(dac_target), BASE);
      wait_cyc(SD);
      chk("R10 busy clears after delay", int'(busy), 0);
      chk("R6 code stays at target", int'(dac_code), BASE);
   endtask

   task automatic t_saturate();
      do_reset();
      do_write(2'd0, 8'h0F);
      chk("R3 adjust clamps high", int'(dac_target), 255);
      do_write(2'd1, 8'h0F);
      do_write(2'd2, 8'd1);
      chk("R3 margin clamps high", int'(dac_target), 255);
   endtask

   initial begin
      t_reset();
      t_adjust_up();
      t_slow_down();
      t_margin_first();
      t_enable_then_level();
      t_retarget_in_delay();
      t_margin_low_and_alt();
      t_saturate();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule